// File: doc/BRIEF.md
# Flow-Through Burst SRAM With No Bus Turnaround

This block is a synthesizable model of a synchronous, flow-through static RAM whose command set needs no idle cycle between reads and writes. Each command is sampled on a rising clock edge. Read data flows out combinationally from the registered address in the cycle after the command. Write data follows its address by exactly one clock. The shared data bus is split into a data-in port, a data-out port and an output-enable. The words are 36 bits wide, arranged as four 9-bit byte lanes. The address width is a parameter. Its default is kept small so that the model elaborates quickly, and setting it to 16 gives the full 64K-word array.

A cycle with the burst-continue input low starts a burst. It loads the external address and latches the read/write direction from that cycle. A cycle with the burst-continue input high steps a 2-bit counter on the low address bits and reuses the latched direction. Three chip selects qualify a burst start. The other inputs modify each cycle:
- The byte-lane write enables mask writes, and a write with every lane disabled becomes a no-op.
- A stall input freezes the whole device for one edge.
- A sleep input turns the bus off and ignores edges.
- An asynchronous output-enable gates the read drivers.

Top module: `zft_sram`

## Requirements
- R1: A selected read start (burst-continue 0, cs_a_n 0, cs_b 1, cs_c_n 0, rd_wrn 1) accepted on an edge drives the stored word at that address on dout, with doe 1, from that same edge until the next accepted edge.
- R2: Continue cycles step only the low 2 address bits, counting up modulo 4 from the start address while the upper bits stay fixed. The fifth beat of a burst therefore returns to the start address.
- R3: A continue cycle (burst-continue 1) reads or writes as fixed by rd_wrn at the burst start, whatever rd_wrn is during the continue cycle.
- R4: A start cycle with any chip select inactive is a deselect. A continue cycle that follows a deselect is a continue-deselect. Neither cycle accesses memory, and doe is 0 after either one.
- R5: A write cycle with all four lane_we_n bits high is an abort and leaves memory unchanged.
- R6: lane_we_n[i] (active low) gates writes to bits [9i+8:9i] only, and the enables are sampled with the address.
- R7: While stall is 1 a clock edge changes nothing. No write happens and the burst state holds. A read in progress keeps driving the same data, and a write in progress keeps the bus off.
- R8: doe is 0 during the data cycle of any write, even while out_en_n is 0.
- R9: While sleep is 1, doe is 0 and clock edges are ignored. When sleep falls, the state from before sleep is restored on the bus.
- R10: While reset is asserted, and after it, doe is 0 until a read is accepted.
- R11: out_en_n acts without a clock edge. A read with out_en_n 1 is a dummy read with doe 0, and lowering out_en_n then drives the same data at once.
- R12: Write data on din is captured at the first non-stalled edge after the write's address edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address for a burst start |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| cont_burst | input | 1 | 1 continues the burst, 0 starts a new cycle |
| rd_wrn | input | 1 | 1 read, 0 write (sampled on start cycles) |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| stall | input | 1 | 1 ignores the clock edge |
| sleep | input | 1 | 1 puts the device to sleep, bus off |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| dout | output | LANES*LANE_W | Read data |
| doe | output | 1 | Drive enable for dout |

## Verification
The embedded assertions check several properties on every cycle:
- Pending reads and writes are mutually exclusive, and the bus is off while a write is pending or the device sleeps.
- Stalled and sleeping edges leave the pipeline and burst counter untouched.
- An abort or deselect never leaves a write pending.
- A continue beat keeps the upper address bits and places the low bits at start plus count.

Only the directed scenarios can show the data behaviours: that written data comes back in wrap order, that lane masks and aborts leave the right bits of memory, and that a stalled write takes its data from the later edge. They also show that a continue cycle ignores the current direction input, and that lowering out_en_n after a dummy read drives the right word.

// File: rtl/zft_pkg.sv
package zft_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    CYC_HOLD,
    CYC_DESEL,
    CYC_READ,
    CYC_WRITE,
    CYC_ABORT
  } cyc_kind_e;

  // Low address bits of a burst beat: linear count, wrapping modulo 4.
  function automatic logic [BURST_W-1:0] burst_low(input logic [BURST_W-1:0] start,
                                                   input logic [BURST_W-1:0] step);
    return start + step;
  endfunction

endpackage

// File: rtl/zft_ctrl.sv
module zft_ctrl
  import zft_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              cont_burst,
  input  logic              rd_wrn,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              stall,
  input  logic              sleep,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pipe_addr,
  output logic [LANES-1:0]  pipe_lanes,
  output logic              rd_live,
  output logic              wr_live
);

  logic              active_q, dir_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic              rd_pend_q, wr_pend_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [LANES-1:0]  p_lanes_q;

  // named events for the assertions
  logic              edge_en, chip_sel, begin_sel, cont_live, acc, acc_wr, all_off;
  logic [BURST_W-1:0] next_step;
  logic [ADDR_W-1:0] acc_addr;
  cyc_kind_e         cyc_kind;

  assign edge_en   = ~stall & ~sleep;
  assign chip_sel  = ~cs_a_n & cs_b & ~cs_c_n;
  assign begin_sel = ~cont_burst & chip_sel;
  assign cont_live = cont_burst & active_q;
  assign acc       = begin_sel | cont_live;
  assign acc_wr    = cont_burst ? dir_wr_q : ~rd_wrn;
  assign all_off   = &lane_we_n;
  assign next_step = cnt_q + BURST_W'(1);
  assign acc_addr  = cont_burst ? {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], next_step)}
                                : addr;

  always_comb begin
    if (!edge_en)     cyc_kind = CYC_HOLD;
    else if (!acc)    cyc_kind = CYC_DESEL;
    else if (!acc_wr) cyc_kind = CYC_READ;
    else if (all_off) cyc_kind = CYC_ABORT;
    else              cyc_kind = CYC_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      dir_wr_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      rd_pend_q <= 1'b0;
      wr_pend_q <= 1'b0;
      p_addr_q  <= '0;
      p_lanes_q <= '0;
    end else if (edge_en) begin
      if (!cont_burst) begin
        active_q <= chip_sel;
        if (chip_sel) begin
          dir_wr_q <= ~rd_wrn;
          base_q   <= addr;
          cnt_q    <= '0;
        end
      end else if (active_q) begin
        cnt_q <= next_step;
      end
      rd_pend_q <= acc & ~acc_wr;
      wr_pend_q <= acc & acc_wr & ~all_off;
      p_addr_q  <= acc_addr;
      p_lanes_q <= ~lane_we_n;
    end
  end

  assign mem_we     = edge_en & wr_pend_q;
  assign pipe_addr  = p_addr_q;
  assign pipe_lanes = p_lanes_q;
  assign rd_live    = rd_pend_q;
  assign wr_live    = wr_pend_q;

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pend_q, wr_pend_q}));  // R8
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_HOLD) |=> $stable(p_addr_q) && $stable(rd_pend_q) && $stable(wr_pend_q) && $stable(cnt_q));  // R7
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_ABORT) |=> !wr_pend_q);  // R5
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_DESEL) |=> !rd_pend_q && !wr_pend_q);  // R4
  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && cont_live) |=> (p_addr_q[ADDR_W-1:BURST_W] == base_q[ADDR_W-1:BURST_W])
      && (p_addr_q[BURST_W-1:0] == BURST_W'(base_q[BURST_W-1:0] + cnt_q)));  // R2

endmodule

// File: rtl/zft_array.sv
module zft_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_en[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = store[addr];
  end

endmodule

// File: rtl/zft_sram.sv
module zft_sram #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    cont_burst,
  input  logic                    rd_wrn,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    stall,
  input  logic                    sleep,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    doe
);

  logic              mem_we, rd_live, wr_live;
  logic [ADDR_W-1:0] pipe_addr;
  logic [LANES-1:0]  pipe_lanes;

  zft_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .cont_burst(cont_burst), .rd_wrn(rd_wrn), .lane_we_n(lane_we_n),
    .stall(stall), .sleep(sleep),
    .mem_we(mem_we), .pipe_addr(pipe_addr), .pipe_lanes(pipe_lanes),
    .rd_live(rd_live), .wr_live(wr_live)
  );

  zft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(mem_we), .addr(pipe_addr), .lane_en(pipe_lanes),
    .wdata(din), .rdata(dout)
  );

  assign doe = rd_live & ~out_en_n & ~sleep;

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |-> !doe);  // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !doe);  // R9

endmodule

// File: tb/sim_zft_sram.sv
module sim_zft_sram;

  localparam int AW = 9;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_a_n = 1'b0, cs_b = 1'b1, cs_c_n = 1'b0;
  logic          cont_burst = 1'b0, rd_wrn = 1'b1;
  logic [3:0]    lane_we_n = 4'hF;
  logic          stall = 1'b0, sleep = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zft_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .cont_burst(cont_burst), .rd_wrn(rd_wrn), .lane_we_n(lane_we_n), .stall(stall),
    .sleep(sleep), .out_en_n(out_en_n), .din(din), .dout(dout), .doe(doe)
  );

  localparam logic [DW-1:0] D0 = 36'h1_2345_6780;
  localparam logic [DW-1:0] D1 = 36'h2_BCDE_F011;
  localparam logic [DW-1:0] D2 = 36'h3_0F0F_0F02;
  localparam logic [DW-1:0] D3 = 36'h4_A5A5_5A53;
  localparam logic [DW-1:0] MASKED = 36'hFF803FE00;
  localparam logic [DW-1:0] JUNK = 36'hD_EADB_EEF0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs as set, sample 2 ns after the edge
  task automatic cyc(input logic c, input logic rd, input logic [AW-1:0] a,
                     input logic [3:0] bw, input logic [DW-1:0] d);
    cs_b = 1'b1; cont_burst = c; rd_wrn = rd; addr = a; lane_we_n = bw; din = d;
    @(posedge clk); #2;
  endtask

  task automatic desel(input logic [DW-1:0] d);
    cs_b = 1'b0; cont_burst = 1'b0; rd_wrn = 1'b1; lane_we_n = 4'hF; din = d;
    @(posedge clk); #2;
    cs_b = 1'b1;
  endtask

  task automatic read_one(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    cyc(1'b0, 1'b1, a, 4'hF, '0);
    chk(req, {35'd0, doe}, 36'd1);
    chk(req, dout, exp);
  endtask

  task automatic write_one(input logic [AW-1:0] a, input logic [3:0] bw, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, a, bw, '0);
    desel(d);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #2; chk("R10 during reset", {35'd0, doe}, 36'd0);
    rst_n = 1'b1;
    desel('0);
    chk("R10 after reset", {35'd0, doe}, 36'd0);
  endtask

  task automatic t_single;
    cyc(1'b0, 1'b0, 9'd5, 4'h0, '0);
    chk("R8 write data cycle", {35'd0, doe}, 36'd0);
    desel(D3);
    read_one("R1 R12 single read", 9'd5, D3);
  endtask

  task automatic t_burst;
    cyc(1'b0, 1'b0, 9'h12, 4'h0, '0);
    cyc(1'b1, 1'b0, 9'h0, 4'h0, D0);
    cyc(1'b1, 1'b0, 9'h0, 4'h0, D1);
    cyc(1'b1, 1'b0, 9'h0, 4'h0, D2);
    desel(D3);
    read_one("R2 beat0 0x12", 9'h12, D0);
    cyc(1'b1, 1'b1, 9'h0, 4'hF, '0); chk("R2 beat1 0x13", dout, D1);
    cyc(1'b1, 1'b1, 9'h0, 4'hF, '0); chk("R2 beat2 wraps to 0x10", dout, D2);
    cyc(1'b1, 1'b1, 9'h0, 4'hF, '0); chk("R2 beat3 0x11", dout, D3);
    cyc(1'b1, 1'b1, 9'h0, 4'hF, '0); chk("R2 beat4 back to start", dout, D0);
    read_one("R2 direct 0x10", 9'h10, D2);
  endtask

  task automatic t_latched_dir;
    read_one("R3 start read", 9'h12, D0);
    cyc(1'b1, 1'b0, 9'h0, 4'h0, '0);
    chk("R3 continue stays read doe", {35'd0, doe}, 36'd1);
    chk("R3 continue stays read data", dout, D1);
    desel(JUNK);
    read_one("R3 memory untouched", 9'h13, D1);
  endtask

  task automatic t_lanes;
    write_one(9'd8, 4'h0, 36'hF_FFFF_FFFF);
    write_one(9'd8, 4'b1010, 36'h0);
    read_one("R6 lanes 0 and 2 only", 9'd8, MASKED);
    cyc(1'b0, 1'b0, 9'd8, 4'hF, '0);
    desel(36'h0);
    read_one("R5 abort leaves memory", 9'd8, MASKED);
  endtask

  task automatic t_dummy;
    out_en_n = 1'b1;
    cyc(1'b0, 1'b1, 9'd8, 4'hF, '0);
    chk("R11 dummy read off", {35'd0, doe}, 36'd0);
    out_en_n = 1'b0; #1;
    chk("R11 async enable", {35'd0, doe}, 36'd1);
    chk("R11 async data", dout, MASKED);
  endtask

  task automatic t_stall;
    read_one("R7 read before stall", 9'h12, D0);
    stall = 1'b1;
    cyc(1'b0, 1'b1, 9'h10, 4'hF, '0);
    chk("R7 stalled read drives", {35'd0, doe}, 36'd1);
    chk("R7 stalled read data", dout, D0);
    stall = 1'b0;
    cyc(1'b0, 1'b0, 9'd20, 4'h0, '0);
    stall = 1'b1;
    cyc(1'b0, 1'b1, 9'd0, 4'hF, JUNK);
    chk("R7 stalled write bus off", {35'd0, doe}, 36'd0);
    stall = 1'b0;
    desel(D2);
    read_one("R12 data from unstalled edge", 9'd20, D2);
  endtask

  task automatic t_desel;
    desel('0);
    chk("R4 deselect off", {35'd0, doe}, 36'd0);
    cyc(1'b1, 1'b1, 9'h0, 4'hF, '0);
    chk("R4 continue-deselect off", {35'd0, doe}, 36'd0);
    cyc(1'b1, 1'b0, 9'h0, 4'h0, '0);
    desel(JUNK);
    read_one("R4 continue-deselect no write", 9'd20, D2);
  endtask

  task automatic t_sleep;
    read_one("R9 read before sleep", 9'h12, D0);
    sleep = 1'b1; #1;
    chk("R9 sleep bus off", {35'd0, doe}, 36'd0);
    cyc(1'b0, 1'b0, 9'h12, 4'h0, '0);
    desel(JUNK);
    sleep = 1'b0; #1;
    chk("R9 wake drives", {35'd0, doe}, 36'd1);
    chk("R9 wake data held", dout, D0);
    read_one("R9 no write while asleep", 9'h12, D0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_latched_dir();
    t_lanes();
    t_dummy();
    t_stall();
    t_desel();
    t_sleep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule